// File: doc/BRIEF.md
# Watchdog Interval Timer With Protected Registers

An 8-bit up-counter advanced by a tap of a free-running 17-bit prescaler. When the counter rolls over from 0xFF to 0x00, the block does one of two things. In interval mode it raises an interrupt request. In watchdog mode it records the event and, if enabled, issues a one-cycle internal reset request. Software restarts ("kicks") the timer by writing 0x00 into the counter.

The counter and the control register can only be changed by a keyed 16-bit write. The upper byte carries a key that picks the target register, and the lower byte carries the data. A write with any other key does nothing. Both status flags can be cleared by software but never set by it. A clear takes effect only if a read earlier saw the flag at 1.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, every register reads 0x00, the counter is stopped, the prescaler is cleared, and `irq` and `rst_req` are low.
- R2: A write to address 0 goes to the counter when `wdata[15:8]` is 0x5A and to the control register when it is 0xA5. The low byte is the data in both cases. A write to address 0 with any other upper byte is ignored, and so is any write to address 1.
- R3: The control register read at address 0 is {ovf, mode, enable, 2'b00, sel[2:0]}. Bit 6 = 1 selects watchdog mode, bit 5 is the timer enable, and bits 2:0 select the prescaler divide. The counter reads at address 1. The reset control register reads at address 2 as {wd_flag, rst_en, 6'b0}.
- R4: While the enable bit is 0, the counter and the prescaler are held at 0.
- R5: After the enable is set with divide D, the counter equals n after the D·n-th rising clock edge. For sel 0..7, D is 2, 64, 128, 512, 2048, 8192, 32768 and 131072.
- R6: A counter write with key 0x5A loads the counter. Writing 0x00 restarts the count while the timer runs.
- R7: A rollover from 0xFF to 0x00 sets ovf (control bit 7). In interval mode, `irq` is high exactly while ovf is 1.
- R8: ovf is cleared only by a control write with bit 7 = 0 that follows a read of address 0 that saw ovf = 1. A write of 0 without such a read, and a write of 1, leave ovf unchanged.
- R9: In watchdog mode, a rollover sets wd_flag and never raises `irq`. If rst_en is 1, `rst_req` pulses for exactly one cycle and ovf is cleared on the next cycle. If rst_en is 0, there is no pulse and ovf stays set.
- R10: wd_flag follows the same read-then-write-0 clear rule through address 2. rst_en is written by any write to address 2 (`wdata[6]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data: key in upper byte, data in lower byte |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interval overflow interrupt request |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The hardest situation to reach is a rollover in a known cycle. At the slowest divide, a rollover takes tens of millions of cycles, and the prescaler phase depends on history. The bench first turns the timer off, which zeroes the prescaler and fixes its phase. It then enables divide 2 and keyed-writes 0xFF into the counter, so the rollover lands on a predictable edge. It samples `rst_req` and `irq` on every cycle around that edge to catch a single-cycle pulse. The clear rules are then tested by ordering reads and zero-writes both with and without the arming read.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_CTL = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [7:0]  rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int PW = 17;

  logic [PW-1:0] pre, mask;
  logic [7:0]    cnt;
  logic [2:0]    sel;
  logic          ovf, ovf_arm, wd_mode, tme;
  logic          wd_flag, wd_arm, rst_en;

  wire cnt_wr = wr_en && addr == 2'd0 && wdata[15:8] == KEY_CNT;
  wire ctl_wr = wr_en && addr == 2'd0 && wdata[15:8] == KEY_CTL;
  wire rc_wr  = wr_en && addr == 2'd2;

  always_comb begin
    case (sel)
      3'd0:    mask = PW'(17'h00001);
      3'd1:    mask = PW'(17'h0003F);
      3'd2:    mask = PW'(17'h0007F);
      3'd3:    mask = PW'(17'h001FF);
      3'd4:    mask = PW'(17'h007FF);
      3'd5:    mask = PW'(17'h01FFF);
      3'd6:    mask = PW'(17'h07FFF);
      default: mask = PW'(17'h1FFFF);
    endcase
  end

  wire tick = tme && ((pre & mask) == mask);
  wire roll = tick && cnt == 8'hFF && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (!tme) pre <= '0;
    else           pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (!tme)   cnt <= '0;
    else if (cnt_wr) cnt <= wdata[7:0];
    else if (tick)   cnt <= cnt + 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_mode <= 1'b0; tme <= 1'b0; sel <= '0;
    end else if (ctl_wr) begin
      wd_mode <= wdata[6]; tme <= wdata[5]; sel <= wdata[2:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            ovf <= 1'b0;
    else if (roll)                         ovf <= 1'b1;
    else if (rst_req)                      ovf <= 1'b0;
    else if (ctl_wr && !wdata[7] && ovf_arm) ovf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              ovf_arm <= 1'b0;
    else if (!ovf)                           ovf_arm <= 1'b0;
    else if (rd_en && addr == 2'd0)          ovf_arm <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              wd_flag <= 1'b0;
    else if (roll && wd_mode)                wd_flag <= 1'b1;
    else if (rc_wr && !wdata[7] && wd_arm)   wd_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              wd_arm <= 1'b0;
    else if (!wd_flag)                       wd_arm <= 1'b0;
    else if (rd_en && addr == 2'd2)          wd_arm <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rst_en <= 1'b0;
    else if (rc_wr) rst_en <= wdata[6];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= roll && wd_mode && rst_en;

  assign irq = ovf && !wd_mode;

  always_comb
    case (addr)
      2'd0:    rdata = {ovf, wd_mode, tme, 2'b00, sel};
      2'd1:    rdata = cnt;
      2'd2:    rdata = {wd_flag, rst_en, 6'b0};
      default: rdata = 8'h00;
    endcase

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tme |=> (cnt == 8'h00 && pre == '0));
  p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_pulse_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !ovf);
  p_ovf_hw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(tick && cnt == 8'hFF));
  p_cnt_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tme && !tick && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, rst_req;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_keyed i_wdt_keyed (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #1;
    d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctl", v, 8'h00);
    rd(2'd1, v); chk("R1 cnt", v, 8'h00);
    rd(2'd2, v); chk("R1 rstctl", v, 8'h00);
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_keys;
    logic [7:0] v;
    wr(2'd0, 16'h1225); wr(2'd0, 16'h5B27); wr(2'd1, 16'hA527);
    rd(2'd0, v); chk("R2 bad key ctl", v, 8'h00);
    edges(10);
    rd(2'd1, v); chk("R2 bad key cnt", v, 8'h00);
    wr(2'd0, 16'hA527);
    rd(2'd0, v); chk("R2 R3 ctl write", v, 8'h27);
    wr(2'd0, 16'h5A40);
    rd(2'd1, v); chk("R2 R6 cnt write", v, 8'h40);
    wr(2'd0, 16'hA507);
    edges(5);
    rd(2'd1, v); chk("R4 held off", v, 8'h00);
  endtask

  task automatic t_rate;
    logic [7:0] v;
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA520);
    edges(6);
    rd(2'd1, v); chk("R5 div2", v, 8'h03);
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA521);
    edges(127);
    rd(2'd1, v); chk("R5 div64 before", v, 8'h01);
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA521);
    edges(128);
    rd(2'd1, v); chk("R5 div64 at", v, 8'h02);
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA522);
    edges(256);
    rd(2'd1, v); chk("R5 div128", v, 8'h02);
  endtask

  task automatic t_restart;
    logic [7:0] v;
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA520);
    edges(20);
    wr(2'd0, 16'h5A00);
    rd(2'd1, v); chk("R6 restart", v, 8'h00);
  endtask

  task automatic t_interval;
    logic [7:0] v;
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA520); wr(2'd0, 16'h5AFF);
    edges(3);
    chk("R7 irq", irq, 1);
    wr(2'd0, 16'hA527);
    chk("R8 clear without read", irq, 1);
    rd(2'd0, v); chk("R7 ovf read", v, 8'hA7);
    wr(2'd0, 16'hA527);
    rd(2'd0, v); chk("R8 cleared", v, 8'h27);
    chk("R7 irq low", irq, 0);
    wr(2'd0, 16'hA5A7);
    rd(2'd0, v); chk("R8 no sw set", v, 8'h27);
  endtask

  task automatic t_watchdog;
    logic [7:0] v;
    int pulses = 0, irqs = 0;
    wr(2'd2, 16'h0040);
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA560); wr(2'd0, 16'h5AFF);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      pulses += rst_req; irqs += irq;
    end
    chk("R9 one pulse", pulses, 1);
    chk("R9 no irq", irqs, 0);
    rd(2'd0, v); chk("R9 ovf cleared", v, 8'h60);
    rd(2'd2, v); chk("R10 wd_flag set", v, 8'hC0);
    wr(2'd2, 16'h0040);
    rd(2'd2, v); chk("R10 cleared after read", v, 8'h40);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'hA500); wr(2'd0, 16'hA560); wr(2'd0, 16'h5AFF);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      pulses += rst_req;
    end
    chk("R9 no pulse when disabled", pulses, 0);
    rd(2'd0, v); chk("R9 ovf kept", v, 8'hE0);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R10 no clear without read", v, 8'h80);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 3 + 1);
    rst_n = 1'b1;
    #(CLK_P);
    t_reset;
    t_keys;
    t_rate;
    t_restart;
    t_interval;
    t_watchdog;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule